// File: doc/BRIEF.md
# Accumulator ALU with status flags

This block is the arithmetic and logic core of a small 8-bit processor. It combines the accumulator with one operand byte, which may come from a register, from memory or from immediate data. The chosen operation returns a result byte in the same cycle. The block also keeps five status flags (sign, zero, auxiliary carry, parity and carry) in a register. That register loads only on a clock edge where the flag-write enable is high.

The carry used by add-with-carry, subtract-with-borrow, complement-carry and the through-carry rotates is the registered carry flag. Every operation owns a fixed subset of the flags. Flags outside that subset keep their old value even when the write enable is high. Operations that touch no flag therefore leave the register unchanged.

Top module: `accum_alu`

## Requirements
- R1: Op code 0 (add) gives acc+opnd and op code 1 (add with carry) gives acc+opnd+carry, both modulo 256. Carry is the carry out of bit 7 and auxiliary carry is the carry out of bit 3. Sign, zero and parity are updated.
- R2: Op code 2 (subtract) gives acc-opnd and op code 3 (subtract with borrow) gives acc-opnd-carry. Carry is set when a borrow out of bit 7 occurs. Auxiliary carry is set on a borrow out of the low nibble. All five flags are updated.
- R3: Op code 4 (compare) sets all five flags exactly as subtract would, while the result output stays equal to the accumulator input.
- R4: Op codes 5, 6 and 7 (AND, OR, XOR) give the bitwise result. Sign, zero and parity are updated, and carry and auxiliary carry are cleared.
- R5: Op codes 8 and 9 increment or decrement the operand byte, and the accumulator input is ignored. Auxiliary carry reflects the low-nibble carry or borrow, sign, zero and parity are updated, and carry keeps its prior value.
- R6: Op code 10 returns the bitwise inverse of the accumulator and changes no flag.
- R7: Op code 11 forces carry to 1 and op code 12 inverts carry. Both return the accumulator unchanged and leave the other four flags alone.
- R8: Op code 13 rotates left with bit 7 going to bit 0 and to carry. Op code 14 rotates right with bit 0 going to bit 7 and to carry. Only carry changes.
- R9: Op code 15 rotates left through carry: old carry goes to bit 0 and bit 7 goes to carry. Op code 16 rotates right through carry: old carry goes to bit 7 and bit 0 goes to carry. Only carry changes.
- R10: Flag output bit positions are sign=4, zero=3, aux=2, parity=1, carry=0. Sign copies result bit 7, zero is set for an all-zero result, and parity is 1 for an even count of ones.
- R11: The flag register loads only on a rising clock edge with the flag-write enable high. Otherwise the flags hold.
- R12: Reset (active low) clears all flags. Op codes 17 to 31 return the accumulator and leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation select |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Operand byte |
| flag_we_i | input | 1 | Flag register write enable |
| result_o | output | 8 | Result byte (combinational) |
| flags_o | output | 5 | Registered flags {sign, zero, aux, parity, carry} |

## Verification
The bench targets the nibble boundaries: 0x0F incremented, 0x00 decremented, and subtracts that borrow out of the low nibble. A design that takes auxiliary carry from the wrong bit or the wrong direction would miss those cases. Carry preservation is checked with carry preset to both 1 and 0 before increment, decrement, complement and the rotates. A design that clears or rewrites carry there would report the wrong flags. Compare is checked for both a zero difference and a borrowing difference, so a design that writes the difference back to the result port is caught. The bench also checks that the through-carry rotates use the old carry, which a plain rotate would not. Disabled flag writes and spare op codes must leave the flags exactly as they were.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [4:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBB = 5'd3,
        OP_CMP = 5'd4,
        OP_AND = 5'd5,
        OP_OR  = 5'd6,
        OP_XOR = 5'd7,
        OP_INC = 5'd8,
        OP_DEC = 5'd9,
        OP_CMA = 5'd10,
        OP_STC = 5'd11,
        OP_CMC = 5'd12,
        OP_RLC = 5'd13,
        OP_RRC = 5'd14,
        OP_RAL = 5'd15,
        OP_RAR = 5'd16
    } alu_op_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic aux;
        logic parity;
        logic carry;
    } flags_t;

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         aux_o
);
    localparam int H = W / 2;

    logic [W:0] full;
    logic [H:0] low;

    always_comb begin
        if (sub_i) begin
            full = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
            low  = {1'b0, a_i[H-1:0]} - {1'b0, b_i[H-1:0]} - {{H{1'b0}}, cin_i};
        end else begin
            full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
            low  = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]} + {{H{1'b0}}, cin_i};
        end
    end

    assign sum_o  = full[W-1:0];
    assign cout_o = full[W];
    assign aux_o  = low[H];
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   sel_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        case (sel_i)
            2'd0:    res_o = a_i & b_i;
            2'd1:    res_o = a_i | b_i;
            2'd2:    res_o = a_i ^ b_i;
            default: res_o = ~a_i;
        endcase
    end
endmodule

// File: rtl/alu_rotate.sv
module alu_rotate #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    input  logic         left_i,
    input  logic         thru_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    logic fill_l;
    logic fill_r;

    assign fill_l = thru_i ? cin_i : a_i[W-1];
    assign fill_r = thru_i ? cin_i : a_i[0];

    always_comb begin
        if (left_i) begin
            res_o  = {a_i[W-2:0], fill_l};
            cout_o = a_i[W-1];
        end else begin
            res_o  = {fill_r, a_i[W-1:1]};
            cout_o = a_i[0];
        end
    end
endmodule

// File: rtl/accum_alu.sv
module accum_alu
    import accalu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4:0]   op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    input  logic         flag_we_i,
    output logic [W-1:0] result_o,
    output logic [4:0]   flags_o
);
    flags_t flags_d, flags_q;

    logic         cy;
    logic         is_step;
    logic [W-1:0] ar_a, ar_b, ar_sum;
    logic         ar_cin, ar_sub, ar_cout, ar_aux;
    logic [1:0]   lg_sel;
    logic [W-1:0] lg_res;
    logic [W-1:0] rt_res;
    logic         rt_cout;

    function automatic flags_t make_flags(input logic [W-1:0] r,
                                          input logic aux, input logic c);
        flags_t f;
        f.sign   = r[W-1];
        f.zero   = (r == '0);
        f.aux    = aux;
        f.parity = ~^r;
        f.carry  = c;
        return f;
    endfunction

    assign cy      = flags_q.carry;
    assign is_step = (op_i == OP_INC) || (op_i == OP_DEC);
    assign ar_a    = is_step ? opnd_i : acc_i;
    assign ar_b    = is_step ? W'(1) : opnd_i;
    assign ar_cin  = ((op_i == OP_ADC) || (op_i == OP_SBB)) ? cy : 1'b0;
    assign ar_sub  = (op_i == OP_SUB) || (op_i == OP_SBB) ||
                     (op_i == OP_CMP) || (op_i == OP_DEC);

    always_comb begin
        case (op_i)
            OP_AND:  lg_sel = 2'd0;
            OP_OR:   lg_sel = 2'd1;
            OP_XOR:  lg_sel = 2'd2;
            default: lg_sel = 2'd3;
        endcase
    end

    alu_arith #(.W(W)) u_arith (
        .a_i(ar_a), .b_i(ar_b), .cin_i(ar_cin), .sub_i(ar_sub),
        .sum_o(ar_sum), .cout_o(ar_cout), .aux_o(ar_aux)
    );

    alu_logic #(.W(W)) u_logic (
        .a_i(acc_i), .b_i(opnd_i), .sel_i(lg_sel), .res_o(lg_res)
    );

    alu_rotate #(.W(W)) u_rotate (
        .a_i(acc_i), .cin_i(cy),
        .left_i((op_i == OP_RLC) || (op_i == OP_RAL)),
        .thru_i((op_i == OP_RAL) || (op_i == OP_RAR)),
        .res_o(rt_res), .cout_o(rt_cout)
    );

    always_comb begin
        flags_d  = flags_q;
        result_o = acc_i;
        case (op_i)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                result_o = ar_sum;
                flags_d  = make_flags(ar_sum, ar_aux, ar_cout);
            end
            OP_CMP: begin
                flags_d = make_flags(ar_sum, ar_aux, ar_cout);
            end
            OP_AND, OP_OR, OP_XOR: begin
                result_o = lg_res;
                flags_d  = make_flags(lg_res, 1'b0, 1'b0);
            end
            OP_INC, OP_DEC: begin
                result_o = ar_sum;
                flags_d  = make_flags(ar_sum, ar_aux, cy);
            end
            OP_CMA: result_o = lg_res;
            OP_STC: flags_d.carry = 1'b1;
            OP_CMC: flags_d.carry = ~cy;
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                result_o      = rt_res;
                flags_d.carry = rt_cout;
            end
            default: ;
        endcase
        if (!flag_we_i) flags_d = flags_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/accum_alu_chk.sv
module accum_alu_chk
    import accalu_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] op_i,
    input logic [7:0] acc_i,
    input logic       flag_we_i,
    input logic [7:0] result_o,
    input logic [4:0] flags_o
);
    // R11
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_i |=> $stable(flags_o));

    // R3
    cmp_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP) |-> (result_o == acc_i));

    // R6
    cma_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && op_i == OP_CMA) |=> $stable(flags_o));

    // R7
    stc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && op_i == OP_STC) |=> (flags_o[0] && flags_o[4:1] == $past(flags_o[4:1])));

    // R5
    incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && (op_i == OP_INC || op_i == OP_DEC)) |=> $stable(flags_o[0]));

    // R4
    logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR))
        |=> (flags_o[0] == 1'b0 && flags_o[2] == 1'b0));

    // R8
    rlc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && op_i == OP_RLC) |=> (flags_o[0] == $past(acc_i[7])));

    // R9
    ral_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RAL) |-> (result_o[0] == flags_o[0]));

    // R10
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && (op_i == OP_ADD || op_i == OP_SUB || op_i == OP_XOR))
        |=> (flags_o[3] == ($past(result_o) == 8'h00)));
endmodule

bind accum_alu accum_alu_chk chk_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i),
    .flag_we_i(flag_we_i), .result_o(result_o), .flags_o(flags_o)
);

// File: tb/accum_alu_tb.sv
module accum_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op = 5'd0;
    logic [7:0] acc = 8'h00;
    logic [7:0] opnd = 8'h00;
    logic       we = 1'b0;
    logic [7:0] res;
    logic [4:0] flg;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    accum_alu dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op), .acc_i(acc), .opnd_i(opnd),
        .flag_we_i(we), .result_o(res), .flags_o(flg)
    );

    // {op[34:30], acc[29:22], opnd[21:14], carry_in[13], result[12:5], flags[4:0]}
    // Flags before each op are {S=0,Z=1,AC=0,P=1,C=carry_in}.
    localparam int NV = 26;
    localparam logic [34:0] VEC [NV] = '{
        {5'd0,  8'h3A, 8'h4C, 1'b0, 8'h86, 5'b10100},
        {5'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 5'b01111},
        {5'd1,  8'h12, 8'h34, 1'b1, 8'h47, 5'b00010},
        {5'd2,  8'h10, 8'h01, 1'b1, 8'h0F, 5'b00110},
        {5'd2,  8'h05, 8'h07, 1'b0, 8'hFE, 5'b10101},
        {5'd3,  8'h05, 8'h05, 1'b1, 8'hFF, 5'b10111},
        {5'd3,  8'h20, 8'h10, 1'b0, 8'h10, 5'b00000},
        {5'd4,  8'h40, 8'h40, 1'b1, 8'h40, 5'b01010},
        {5'd4,  8'h30, 8'h50, 1'b0, 8'h30, 5'b10001},
        {5'd5,  8'hF0, 8'h3C, 1'b1, 8'h30, 5'b00010},
        {5'd6,  8'h00, 8'h00, 1'b1, 8'h00, 5'b01010},
        {5'd7,  8'h5A, 8'hFF, 1'b0, 8'hA5, 5'b10010},
        {5'd8,  8'h77, 8'h0F, 1'b1, 8'h10, 5'b00101},
        {5'd8,  8'h77, 8'hFF, 1'b0, 8'h00, 5'b01110},
        {5'd9,  8'h77, 8'h00, 1'b1, 8'hFF, 5'b10111},
        {5'd9,  8'h77, 8'h01, 1'b0, 8'h00, 5'b01010},
        {5'd10, 8'h5A, 8'h00, 1'b1, 8'hA5, 5'b01011},
        {5'd11, 8'h33, 8'h00, 1'b0, 8'h33, 5'b01011},
        {5'd12, 8'h33, 8'h00, 1'b1, 8'h33, 5'b01010},
        {5'd13, 8'h81, 8'h00, 1'b0, 8'h03, 5'b01011},
        {5'd14, 8'h01, 8'h00, 1'b0, 8'h80, 5'b01011},
        {5'd15, 8'h80, 8'h00, 1'b0, 8'h00, 5'b01011},
        {5'd15, 8'h40, 8'h00, 1'b1, 8'h81, 5'b01010},
        {5'd16, 8'h01, 8'h00, 1'b0, 8'h00, 5'b01011},
        {5'd16, 8'h02, 8'h00, 1'b1, 8'h81, 5'b01010},
        {5'd31, 8'h9C, 8'h00, 1'b1, 8'h9C, 5'b01011}
    };

    function automatic string tag_of(input logic [4:0] o);
        case (o)
            5'd0, 5'd1:                 return "R1 R10";
            5'd2, 5'd3:                 return "R2 R10";
            5'd4:                       return "R3 R10";
            5'd5, 5'd6, 5'd7:           return "R4 R10";
            5'd8, 5'd9:                 return "R5 R10";
            5'd10:                      return "R6";
            5'd11, 5'd12:               return "R7";
            5'd13, 5'd14:               return "R8";
            5'd15, 5'd16:               return "R9";
            default:                    return "R12";
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [4:0] o, input logic [7:0] a,
                          input logic [7:0] b, input logic w,
                          output logic [7:0] r, output logic [4:0] f);
        @(negedge clk);
        op = o; acc = a; opnd = b; we = w;
        #1 r = res;
        @(posedge clk);
        #1 f = flg;
    endtask

    task automatic prime(input logic c);
        logic [7:0] r;
        logic [4:0] f;
        run_op(5'd0, 8'h00, 8'h00, 1'b1, r, f);
        if (c) run_op(5'd11, 8'h00, 8'h00, 1'b1, r, f);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [4:0] f;

        // R12: reset state
        repeat (3) @(posedge clk);
        #1 check(flg == 5'b0, "R12", "flags in reset", {3'b0, flg}, 8'h00);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1 check(flg == 5'b0, "R12", "flags after reset", {3'b0, flg}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [34:0] v;
            v = VEC[i];
            prime(v[13]);
            run_op(v[34:30], v[29:22], v[21:14], 1'b1, r, f);
            check(r == v[12:5], tag_of(v[34:30]), $sformatf("vec %0d result", i), r, v[12:5]);
            check(f == v[4:0], tag_of(v[34:30]), $sformatf("vec %0d flags", i), {3'b0, f}, {3'b0, v[4:0]});
        end

        // R11: flag write disabled, result still computed
        prime(1'b1);
        run_op(5'd0, 8'hFF, 8'h01, 1'b0, r, f);
        check(r == 8'h00, "R11", "result with write off", r, 8'h00);
        check(f == 5'b01011, "R11", "flags held with write off", {3'b0, f}, 8'h0B);

        // R11: subtract that would set carry, write off
        run_op(5'd2, 8'h00, 8'h01, 1'b0, r, f);
        check(f == 5'b01011, "R11", "flags held after sub", {3'b0, f}, 8'h0B);

        // R9: chained through-carry rotate uses old carry each step
        prime(1'b0);
        run_op(5'd15, 8'h80, 8'h00, 1'b1, r, f);
        run_op(5'd15, 8'h00, 8'h00, 1'b1, r, f);
        check(r == 8'h01, "R9", "second RAL result", r, 8'h01);
        check(f[0] == 1'b0, "R9", "second RAL carry", {7'b0, f[0]}, 8'h00);

        // R12: reset mid-run clears flags
        prime(1'b1);
        @(negedge clk) rst_n = 1'b0;
        #1 check(flg == 5'b0, "R12", "flags after mid-run reset", {3'b0, flg}, 8'h00);
        @(negedge clk) rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule